// File: doc/BRIEF.md
# Serial ADC Conversion Host

This block is the host side of a serial link to an eight-input, 12-bit converter. A single request carries a channel number and two mode flags: unipolar/bipolar and single-ended/differential. From these the block builds the converter's configuration byte. It always sets the start bit and always selects the externally clocked conversion mode.

The block then runs one frame on an SPI mode 0 link. It lowers chip select and sends 24 clocks as three byte transfers. The first byte carries the configuration and the other two send zeros. Data from the converter is shifted in at the same time. The block returns 12 bits taken from the middle of the received frame, together with a one-cycle done pulse.

The serial clock rate is set from the system clock frequency and a target SCLK frequency. Both are parameters, and their combination is checked at elaboration.

Top module: `adc_spi_host`

## Requirements
- R1: SCLK idles low and is low whenever CS is high. Each SCLK half-period lasts DIV_HALF = SYS_CLK_HZ/(2*SCLK_HZ) system clocks, so rising edges are 2*DIV_HALF clocks apart. Elaboration rejects SCLK_HZ outside 100 kHz..2 MHz and rejects DIV_HALF below 1.
- R2: Each accepted request produces exactly 24 SCLK rising edges. CS goes low before the first edge and stays low until after the last one.
- R3: The first eight bits on MOSI, MSB first, are {1, chan[2:0], unipolar, single, 1, 1}.
- R4: MOSI is 0 for the 16 rising edges of the second and third bytes.
- R5: MOSI changes only while SCLK is low. It is updated at falling edges so that it is stable at every rising edge.
- R6: MISO is sampled at each rising edge. Counting the first received bit as bit 23, result_o equals received bits 22 down to 11.
- R7: done_o is high for exactly one system clock. result_o is valid in that cycle and holds its value until the next done.
- R8: busy_o is high from the cycle after a request is accepted until done. A request while busy_o is high is ignored and starts no further frame.
- R9: CS rises after the last falling edge. CS then stays high for at least 2*DIV_HALF system clocks before the next frame lowers it.
- R10: During and right after reset, cs_no is 1 and sclk_o, mosi_o, busy_o and done_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start one conversion when not busy |
| chan_i | input | 3 | Converter input channel |
| unipolar_i | input | 1 | 1 = unipolar range, 0 = bipolar |
| single_i | input | 1 | 1 = single-ended, 0 = differential |
| busy_o | output | 1 | Frame in progress, requests ignored |
| done_o | output | 1 | One-cycle pulse, result valid |
| result_o | output | 12 | Conversion result |
| cs_no | output | 1 | Converter chip select, active low |
| sclk_o | output | 1 | Serial clock, idle low |
| mosi_o | output | 1 | Data to the converter |
| miso_i | input | 1 | Data from the converter |

## Verification
The bench builds the block with SYS_CLK_HZ = 8 MHz and SCLK_HZ = 2 MHz, which gives a two-clock half-period. At that setting a full frame, including its guard gap, takes about a hundred cycles, so the bench can sweep every channel against all four mode-flag combinations. The bench also runs edge-value result words, and a converter model places inverted guard bits around the 12-bit field, so a result sliced one bit off in either direction gives a wrong value. With the short divider, the half-period count, the CS gap and the MOSI update edge can all be measured clock by clock within each frame.

// File: rtl/adc_spi_pkg.sv
package adc_spi_pkg;
  localparam int CH_W    = 3;
  localparam int RES_W   = 12;
  localparam int BYTE_W  = 8;
  localparam int N_BYTES = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LO,
    ST_HI,
    ST_TAIL,
    ST_GAP
  } st_e;

  // start bit forced, external-clock mode forced
  function automatic logic [BYTE_W-1:0] cfg_byte(input logic [CH_W-1:0] chan,
                                                 input logic uni,
                                                 input logic sgl);
    return {1'b1, chan, uni, sgl, 2'b11};
  endfunction
endpackage

// File: rtl/adc_spi_tick.sv
module adc_spi_tick #(
  parameter int HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!run_i)    cnt_q <= '0;
    else if (tick_o)    cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/adc_spi_shreg.sv
module adc_spi_shreg #(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_i,
  input  logic         sample_i,
  input  logic         miso_i,
  output logic         mosi_o,
  output logic [W-1:0] rx_o
);
  logic [W-1:0] tx_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tx_q <= '0;
    else if (load_i)  tx_q <= load_val_i;
    else if (shift_i) tx_q <= {tx_q[W-2:0], 1'b0};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rx_q <= '0;
    else if (load_i)   rx_q <= '0;
    else if (sample_i) rx_q <= {rx_q[W-2:0], miso_i};
  end

  assign mosi_o = tx_q[W-1];
  assign rx_o   = rx_q;
endmodule

// File: rtl/adc_spi_host.sv
module adc_spi_host
  import adc_spi_pkg::*;
#(
  parameter int SYS_CLK_HZ = 100_000_000,
  parameter int SCLK_HZ    = 2_000_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [CH_W-1:0]  chan_i,
  input  logic             unipolar_i,
  input  logic             single_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [RES_W-1:0] result_o,
  output logic             cs_no,
  output logic             sclk_o,
  output logic             mosi_o,
  input  logic             miso_i
);
  localparam int DIV_HALF   = SYS_CLK_HZ / (2 * SCLK_HZ);
  localparam int FRAME_BITS = N_BYTES * BYTE_W;
  localparam int BIT_W      = $clog2(FRAME_BITS);
  localparam int RES_HI     = FRAME_BITS - 2;
  localparam int RES_LO     = RES_HI - RES_W + 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);

  if (SCLK_HZ < 100_000 || SCLK_HZ > 2_000_000) begin : g_bad_rate
    $error("adc_spi_host: SCLK_HZ out of range");
  end
  if (DIV_HALF < 1) begin : g_bad_div
    $error("adc_spi_host: half-period below one system clock");
  end

  st_e              st_q;
  logic [BIT_W-1:0] bit_q;
  logic             gap_q;
  logic             tick;
  logic             run;
  logic             accept;
  logic [FRAME_BITS-1:0] rx_frame;
  logic [FRAME_BITS-1:0] frame_tx;

  assign accept   = (st_q == ST_IDLE) && req_i;
  assign run      = (st_q != ST_IDLE);
  assign frame_tx = {cfg_byte(chan_i, unipolar_i, single_i), {(FRAME_BITS-BYTE_W){1'b0}}};

  adc_spi_tick #(.HALF(DIV_HALF)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .tick_o (tick)
  );

  adc_spi_shreg #(.W(FRAME_BITS)) u_shreg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .load_val_i (frame_tx),
    .shift_i    ((st_q == ST_HI) && tick && (bit_q != LAST_BIT)),
    .sample_i   ((st_q == ST_LO) && tick),
    .miso_i     (miso_i),
    .mosi_o     (mosi_o),
    .rx_o       (rx_frame)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      bit_q    <= '0;
      gap_q    <= 1'b0;
      cs_no    <= 1'b1;
      sclk_o   <= 1'b0;
      busy_o   <= 1'b0;
      done_o   <= 1'b0;
      result_o <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_i) begin
          st_q   <= ST_LO;
          cs_no  <= 1'b0;
          busy_o <= 1'b1;
          bit_q  <= '0;
        end
        ST_LO: if (tick) begin
          sclk_o <= 1'b1;
          st_q   <= ST_HI;
        end
        ST_HI: if (tick) begin
          sclk_o <= 1'b0;
          if (bit_q == LAST_BIT) st_q <= ST_TAIL;
          else begin
            bit_q <= bit_q + 1'b1;
            st_q  <= ST_LO;
          end
        end
        ST_TAIL: if (tick) begin
          cs_no <= 1'b1;
          gap_q <= 1'b0;
          st_q  <= ST_GAP;
        end
        ST_GAP: if (tick) begin
          if (gap_q) begin
            st_q     <= ST_IDLE;
            done_o   <= 1'b1;
            busy_o   <= 1'b0;
            result_o <= rx_frame[RES_HI:RES_LO];
          end else gap_q <= 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_spi_host_chk.sv
module adc_spi_host_chk #(
  parameter int HALF = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_no,
  input logic sclk_o,
  input logic mosi_o,
  input logic busy_o,
  input logic done_o
);
  localparam int GAP_MIN = 2 * HALF;
  localparam int GW = $clog2(GAP_MIN + 2);

  logic         sclk_d;
  logic [5:0]   rise_cnt;
  logic [GW-1:0] hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d   <= 1'b0;
      rise_cnt <= '0;
      hi_cnt   <= GW'(GAP_MIN);
    end else begin
      sclk_d <= sclk_o;
      if (cs_no) rise_cnt <= '0;
      else if (sclk_o && !sclk_d) rise_cnt <= rise_cnt + 1'b1;
      if (!cs_no) hi_cnt <= '0;
      else if (hi_cnt < GW'(GAP_MIN)) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  a_r1_sclk_low_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);
  a_r2_edge_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_cnt <= 6'd24);
  a_r4_zero_tail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && sclk_o && !sclk_d && rise_cnt >= 6'd8) |-> !mosi_o);
  a_r5_mosi_low_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mosi_o) |-> !sclk_o);
  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r8_busy_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> busy_o);
  a_r9_cs_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> (hi_cnt >= GW'(GAP_MIN)));
endmodule

bind adc_spi_host adc_spi_host_chk #(.HALF(DIV_HALF)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cs_no  (cs_no),
  .sclk_o (sclk_o),
  .mosi_o (mosi_o),
  .busy_o (busy_o),
  .done_o (done_o)
);

// File: tb/sim_adc_spi_host.sv
module sim_adc_spi_host;
  localparam int SYS_HZ = 8_000_000;
  localparam int SCK_HZ = 2_000_000;
  localparam int DH     = SYS_HZ / (2 * SCK_HZ);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, uni = 1'b0, sgl = 1'b0, miso = 1'b0;
  logic [2:0] chan = '0;
  logic busy, done, cs_n, sclk, mosi;
  logic [11:0] result;

  always #5 clk = ~clk;

  adc_spi_host #(.SYS_CLK_HZ(SYS_HZ), .SCLK_HZ(SCK_HZ)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .chan_i(chan),
    .unipolar_i(uni), .single_i(sgl), .busy_o(busy), .done_o(done),
    .result_o(result), .cs_no(cs_n), .sclk_o(sclk), .mosi_o(mosi),
    .miso_i(miso));

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // converter model and link monitor, sampled at falling clk edges
  logic [23:0] word = '0, cap = '0;
  int rises = 0, falls_in = 0, cs_falls = 0, bad_idle = 0, bad_per = 0, bad_r5 = 0;
  int last_rise = 0, hi_run = 1000, last_gap = 0;
  logic sclk_p = 1'b0, cs_p = 1'b1, mosi_p = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (cs_n && sclk) bad_idle++;
      if (!cs_n && cs_p) begin
        cs_falls++; rises = 0; falls_in = 0; cap = '0; last_gap = hi_run;
        miso = word[23];
      end
      if (sclk && !sclk_p) begin
        if (rises > 0 && (cyc - last_rise) != 2 * DH) bad_per++;
        last_rise = cyc;
        cap = {cap[22:0], mosi};
        rises++;
      end
      if (sclk && sclk_p && mosi != mosi_p) bad_r5++;
      if (!sclk && sclk_p && !cs_n) begin
        falls_in++;
        if (falls_in < 24) miso = word[23 - falls_in];
      end
      hi_run = cs_n ? hi_run + 1 : 0;
    end
    sclk_p = sclk; cs_p = cs_n; mosi_p = mosi;
  end

  task automatic conv(input logic [2:0] c, input bit u, input bit s,
                      input logic [11:0] val, input bit poke);
    int t;
    int f0;
    while (busy) @(negedge clk);
    word = {~val[11], val, ~val[10:0]};
    f0 = cs_falls;
    bad_idle = 0; bad_per = 0; bad_r5 = 0;
    chan = c; uni = u; sgl = s; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    chk(busy == 1'b1, "R8 busy after accept", busy, 1);
    if (poke) begin
      repeat (20) @(negedge clk);
      chan = ~c; uni = ~u; req = 1'b1;
      @(negedge clk);
      req = 1'b0;
    end
    t = 0;
    while (!done && t < 2000) begin @(negedge clk); t++; end
    chk(done == 1'b1, "R7 done seen", done, 1);
    chk(result == val, "R6 result slice", result, val);
    chk(cap[23:16] == {1'b1, c, u, s, 2'b11}, "R3 config byte", cap[23:16], {1'b1, c, u, s, 2'b11});
    chk(cap[15:0] == 16'h0, "R4 zero bytes", cap[15:0], 0);
    chk(rises == 24, "R2 edge count", rises, 24);
    chk(bad_idle == 0, "R1 sclk low with cs high", bad_idle, 0);
    chk(bad_per == 0, "R1 sclk period", bad_per, 0);
    chk(bad_r5 == 0, "R5 mosi stable high", bad_r5, 0);
    chk(cs_falls - f0 == 1, "R8 one frame per request", cs_falls - f0, 1);
    chk(last_gap >= 2 * DH, "R9 cs idle gap", last_gap, 2 * DH);
    @(negedge clk);
    chk(done == 1'b0, "R7 done single cycle", done, 0);
    chk(result == val, "R7 result held", result, val);
    chk(cs_n == 1'b1 && busy == 1'b0, "R9 cs released", {cs_n, busy}, 2'b10);
    if (poke) begin
      repeat (10) @(negedge clk);
      chk(cs_n == 1'b1 && cs_falls - f0 == 1, "R8 ignored request", cs_falls - f0, 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({cs_n, sclk, mosi, busy, done} == 5'b10000, "R10 in reset", {cs_n, sclk, mosi, busy, done}, 5'b10000);
    rst_n = 1'b1;
    @(negedge clk);
    chk({cs_n, sclk, mosi, busy, done} == 5'b10000, "R10 after reset", {cs_n, sclk, mosi, busy, done}, 5'b10000);
    for (int c = 0; c < 8; c++)
      for (int m = 0; m < 4; m++)
        conv(3'(c), m[1], m[0], 12'((c * 291 + m * 1031 + 7) & 12'hfff), 1'b0);
    conv(3'd0, 1'b1, 1'b1, 12'h000, 1'b0);
    conv(3'd7, 1'b0, 1'b0, 12'hfff, 1'b0);
    conv(3'd5, 1'b1, 1'b0, 12'haaa, 1'b1);
    conv(3'd2, 1'b0, 1'b1, 12'h555, 1'b1);
    conv(3'd3, 1'b1, 1'b1, 12'h801, 1'b0);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule